// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block sorts every reset event into one of two classes and drives the reset lines of a chip's domains to match. The inputs are an active-low reset pin, an active-low test-reset pin with its own test clock, and a one-cycle watchdog-expiry pulse on the system clock. A cold reset comes from both pins low at once or from a watchdog expiry. It resets the core, emulation and PLL domains and asks for on-chip memory to be cleared. A warm reset comes from the reset pin alone while the test-reset pin stays high. It resets only the core and leaves the emulation domain, the PLL and the memory contents alone.

The reset pin is synchronized to the system clock. Core release waits a fixed number of system clocks after the synchronized pin goes high. For the whole of either sequence a busy output is driven for other controllers and a global pad tri-state enable is raised. The emulation reset is asserted asynchronously and released on the test clock. This lets the test-reset pin stay low for as long as needed while the core runs. A two-bit cause register records what started the last sequence. The real-time-clock reset output is never asserted.

Top module: `reset_sequencer`

## Requirements
- R1: With `rst_ni` and `trst_ni` both low, the sequence is cold: `core_rst_no`, `emu_rst_no` and `pll_rst_no` are low, `mem_init_o` is high and `rst_cause_o` reads 2'b01.
- R2: `rst_ni` low while `trst_ni` is high starts a warm sequence. `core_rst_no` drops at once, while `pll_rst_no` and `emu_rst_no` stay high and `mem_init_o` stays low. After the next system clock edge `rst_cause_o` reads 2'b10.
- R3: A `wdog_expire_i` pulse sampled while the core is running starts a cold sequence with `rst_cause_o` = 2'b11. It takes priority over a reset pin falling in the same cycle. A pulse sampled while a sequence is active is ignored.
- R4: `rst_busy_o` and `pad_hiz_o` are high exactly while `core_rst_no` is low, for both classes.
- R5: `rtc_rst_no` is high at all times.
- R6: After a pin-started sequence, `core_rst_no` rises on the 18th rising `clk_i` edge after `rst_ni` goes high: 2 synchronizer stages followed by 16 hold clocks. A watchdog-started sequence holds `core_rst_no` low for exactly 16 clocks.
- R7: The core leaves reset while `trst_ni` stays low, and `emu_rst_no` then stays low for as long as `trst_ni` does.
- R8: `emu_rst_no` is low while `trst_ni` is low or a cold sequence is active. It rises on the 2nd rising `tck_i` edge after both conditions clear.
- R9: `rst_cause_o` changes only when a sequence is entered from the running state, so it is kept through the hold phase. A reset pin pulse during the hold phase restarts the 16-clock count and keeps the class and the cause.
- R10: After a cold sequence, `pll_rst_no` rises and `mem_init_o` falls in the same cycle that `core_rst_no` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| tck_i | input | 1 | Test clock for the emulation reset release |
| rst_ni | input | 1 | External reset pin, active low |
| trst_ni | input | 1 | External test-reset pin, active low |
| wdog_expire_i | input | 1 | Watchdog expiry, one-cycle pulse on clk_i |
| core_rst_no | output | 1 | Core domain reset, active low |
| emu_rst_no | output | 1 | Emulation domain reset, active low, released on tck_i |
| pll_rst_no | output | 1 | PLL domain reset, active low |
| rtc_rst_no | output | 1 | Real-time-clock reset, held inactive |
| mem_init_o | output | 1 | On-chip memory clear request |
| rst_busy_o | output | 1 | Reset sequence in progress, for external controllers |
| pad_hiz_o | output | 1 | Global pad tri-state enable |
| rst_cause_o | output | 2 | Cause of the last sequence: 00 none, 01 power-on, 10 warm, 11 watchdog |

## Verification
The bench sweeps warm pin pulses from one to six clocks and repeats watchdog expiries, measuring the release edge each time. An off-by-one hold counter or a missing synchronizer stage would move that edge away from 18 or 16. It drives a watchdog pulse on the same edge the pin falls, and another during a warm hold. A design with the wrong priority would report a warm cause, and one that does not ignore the late pulse would reset the PLL. It pulses the pin again during the hold phase and holds the test-reset pin low while the core runs. A design that does not restart the count, or that ties the emulation reset to the core, releases early or frees the emulation domain.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_WARM = 2'b10,
    CAUSE_WDOG = 2'b11
  } rst_cause_e;
endpackage

// File: rtl/rstseq_sync.sv
// N-stage synchronizer with asynchronous load of RST_VAL.
module rstseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned HOLD = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,      // power-on: both pins low
  input  logic       pin_ok_i,    // synchronized reset pin
  input  logic       tst_ok_i,    // synchronized test-reset pin
  input  logic       wdog_i,
  output logic       run_o,
  output logic       cold_o,
  output rst_cause_e cause_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic          in_rst_q, cold_q;
  logic [CW-1:0] cnt_q;
  rst_cause_e    cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q <= 1'b1;
      cold_q   <= 1'b1;
      cnt_q    <= '0;
      cause_q  <= CAUSE_POR;
    end else if (!in_rst_q) begin
      if (wdog_i) begin
        in_rst_q <= 1'b1;
        cold_q   <= 1'b1;
        cnt_q    <= '0;
        cause_q  <= CAUSE_WDOG;
      end else if (!pin_ok_i) begin
        in_rst_q <= 1'b1;
        cold_q   <= !tst_ok_i;
        cnt_q    <= '0;
        cause_q  <= tst_ok_i ? CAUSE_WARM : CAUSE_POR;
      end
    end else if (!pin_ok_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(HOLD - 1)) begin
      in_rst_q <= 1'b0;
      cold_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o   = !in_rst_q;
  assign cold_o  = cold_q;
  assign cause_o = cause_q;

  // R3
  wdog_cold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rst_q && wdog_i |=> in_rst_q && cold_q && cause_q == CAUSE_WDOG);
  // R2
  warm_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rst_q && !wdog_i && !pin_ok_i && tst_ok_i |=> in_rst_q && !cold_q && cause_q == CAUSE_WARM);
  // R9
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rst_q |=> $stable(cause_q));
  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rst_q && !pin_ok_i |=> in_rst_q && cnt_q == '0 && $stable(cold_q));
  // R6
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_rst_q) |-> $past(cnt_q) == CW'(HOLD - 1) && $past(pin_ok_i));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EMU_STAGES  = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       trst_ni,
  input  logic       wdog_expire_i,
  output logic       core_rst_no,
  output logic       emu_rst_no,
  output logic       pll_rst_no,
  output logic       rtc_rst_no,
  output logic       mem_init_o,
  output logic       rst_busy_o,
  output logic       pad_hiz_o,
  output logic [1:0] rst_cause_o
);
  logic       por_n, pin_ok, tst_ok, run, cold, emu_clr_n;
  rst_cause_e cause;

  // power-on when both pins low together
  assign por_n = rst_ni | trst_ni;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(pin_ok)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tst_sync (
    .clk_i (clk_i), .rst_ni(por_n), .d_i(trst_ni), .q_o(tst_ok)
  );

  rstseq_fsm #(.HOLD(HOLD_CYCLES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (por_n),
    .pin_ok_i(pin_ok),
    .tst_ok_i(tst_ok),
    .wdog_i  (wdog_expire_i),
    .run_o   (run),
    .cold_o  (cold),
    .cause_o (cause)
  );

  // cold sequences also hold emulation logic; release on the test clock
  assign emu_clr_n = trst_ni & ~cold;

  rstseq_sync #(.STAGES(EMU_STAGES), .RST_VAL(1'b0)) u_emu_sync (
    .clk_i (tck_i), .rst_ni(emu_clr_n), .d_i(1'b1), .q_o(emu_rst_no)
  );

  assign core_rst_no = run & pin_ok;
  assign pll_rst_no  = ~cold;
  assign mem_init_o  = cold;
  assign rst_busy_o  = ~core_rst_no;
  assign pad_hiz_o   = ~core_rst_no;
  assign rtc_rst_no  = 1'b1;
  assign rst_cause_o = cause;

  // R8
  emu_hold_chk: assert property (@(posedge tck_i) !trst_ni |-> !emu_rst_no);
  // R10
  cold_release_chk: assert property (@(posedge clk_i) disable iff (!por_n)
    $rose(pll_rst_no) |-> core_rst_no && !mem_init_o);
  // R2
  warm_keep_pll_chk: assert property (@(posedge clk_i) disable iff (!por_n)
    !core_rst_no && $past(core_rst_no) && !wdog_expire_i && $past(!wdog_expire_i) && trst_ni && $past(trst_ni) |-> pll_rst_no);
endmodule

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 14;

  logic clk = 1'b0, tck = 1'b0;
  logic rst_n = 1'b0, trst_n = 1'b0, wdog = 1'b0;
  logic core_rst_n, emu_rst_n, pll_rst_n, rtc_rst_n, mem_init, busy, hiz;
  logic [1:0] cause;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TCK_PERIOD/2) tck = ~tck;

  reset_sequencer dut (
    .clk_i(clk), .tck_i(tck), .rst_ni(rst_n), .trst_ni(trst_n),
    .wdog_expire_i(wdog), .core_rst_no(core_rst_n), .emu_rst_no(emu_rst_n),
    .pll_rst_no(pll_rst_n), .rtc_rst_no(rtc_rst_n), .mem_init_o(mem_init),
    .rst_busy_o(busy), .pad_hiz_o(hiz), .rst_cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_side(input string req);
    chk({req, "/R4 busy"}, busy, !core_rst_n);
    chk({req, "/R4 hiz"}, hiz, !core_rst_n);
    chk({req, "/R5 rtc"}, rtc_rst_n, 1);
  endtask

  // negedges from rst_n rising (or wdog capture) until core_rst_no is high
  task automatic count_release(output int n);
    n = 0;
    while (!core_rst_n && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic emu_settle();
    repeat (3) @(posedge tck);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 power-on state
    chk("R1 core", core_rst_n, 0);
    chk("R1 emu", emu_rst_n, 0);
    chk("R1 pll", pll_rst_n, 0);
    chk("R1 mem", mem_init, 1);
    chk("R1 cause", cause, 1);
    chk_side("R1");
    rst_n = 1'b1; trst_n = 1'b1;
    count_release(n);
    chk("R6 por release", n, 18);
    chk("R10 pll", pll_rst_n, 1);
    chk("R10 mem", mem_init, 0);
    chk_side("R6");
    emu_settle();
    chk("R8 emu free", emu_rst_n, 1);

    // warm sweep over pulse widths
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R2 core drop", core_rst_n, 0);
      chk_side("R2");
      repeat (k) @(negedge clk);
      chk("R2 pll kept", pll_rst_n, 1);
      chk("R2 emu kept", emu_rst_n, 1);
      chk("R2 mem", mem_init, 0);
      chk("R2 cause", cause, 2);
      rst_n = 1'b1;
      count_release(n);
      chk("R6 warm release", n, 18);
    end

    // R9 restart during hold
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 still held", core_rst_n, 0);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    count_release(n);
    chk("R9 restart count", n, 18);
    chk("R9 cause kept", cause, 2);

    // R3 watchdog sweep
    for (int w = 0; w < 3; w++) begin
      repeat (w + 2) @(negedge clk);
      wdog = 1'b1;
      @(negedge clk); wdog = 1'b0;
      chk("R3 core", core_rst_n, 0);
      chk("R3 pll", pll_rst_n, 0);
      chk("R3 mem", mem_init, 1);
      chk("R3 cause", cause, 3);
      chk_side("R3");
      #1;
      chk("R8 emu cold", emu_rst_n, 0);
      count_release(n);
      chk("R6 wdog length", n, 16);
      chk("R10 pll after wdog", pll_rst_n, 1);
      emu_settle();
      chk("R8 emu after wdog", emu_rst_n, 1);
    end

    // R3 watchdog beats a same-cycle pin fall
    @(negedge clk); wdog = 1'b1; rst_n = 1'b0;
    @(negedge clk); wdog = 1'b0;
    chk("R3 prio cause", cause, 3);
    chk("R3 prio pll", pll_rst_n, 0);
    @(negedge clk); rst_n = 1'b1;
    count_release(n);
    chk("R6 prio release", n, 18);

    // R3 watchdog ignored during warm hold
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); wdog = 1'b1;
    @(negedge clk); wdog = 1'b0;
    chk("R3 ignored pll", pll_rst_n, 1);
    chk("R3 ignored mem", mem_init, 0);
    chk("R3 ignored cause", cause, 2);
    rst_n = 1'b1;
    count_release(n);
    chk("R3 ignored release", n, 18);

    // R7 test-reset held low while running
    @(negedge clk); trst_n = 1'b0;
    #1;
    chk("R8 emu async", emu_rst_n, 0);
    repeat (30) @(negedge clk);
    chk("R7 core runs", core_rst_n, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 por again cause", cause, 1);
    chk("R1 por again pll", pll_rst_n, 0);
    rst_n = 1'b1;
    count_release(n);
    chk("R7 release with trst low", n, 18);
    emu_settle();
    chk("R7 emu held", emu_rst_n, 0);
    trst_n = 1'b1;
    emu_settle();
    chk("R8 emu release", emu_rst_n, 1);
    chk("R5 rtc end", rtc_rst_n, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule